// File: doc/BRIEF.md
# Bit-Serial Port with Programming-Mode Flash Loader

This block is a byte-wide serial port for a very small secure controller. A single shift register, mapped into the CPU's data space, moves one bit per serial tick. In receive mode, bits enter from the serial input, most significant bit first. In transmit mode, bits leave from the top of the register onto the serial output. Software controls the port through a second mapped location, the status/control word. It holds a ready flag that is raised after every completed group of eight shifts, a direction bit, and a sticky overrun flag.

The direction of the port is sampled once, while reset is active. If the programming-mode input is high at that time, the port becomes a hardware loader. The CPU is held in reset and the port is locked to receive. Each completed byte is issued to the flash controller as a one-cycle write strobe with its data. The flash byte address then steps by one, so an external programmer can stream an image into flash without running any code. An optional block rollover extends this from block zero to the whole array.

Top module: `serial_loader`

## Requirements
- R1: After reset the status word reads 0, cpuHold (when programming mode was low) is 0, flashWrStrobe is 0, serDataOut is 1, and both flash address outputs are 0.
- R2: In receive mode (status bit 1 = 0), each serTick shifts serDataIn into bit 0 of the data register while the older bits move up. The first bit received therefore ends in bit 7.
- R3: Status bit 0 (ready) is 0 after seven shifts of a byte and reads 1 in the cycle after the eighth shift.
- R4: In receive mode, a CPU read of the data location (cpuAddr = 0) returns the received byte and clears ready.
- R5: A shift that occurs while ready is 1, and is not accompanied by a ready-clearing access, sets status bit 2 (overrun). Writing the status location with bit 2 = 1 clears overrun.
- R6: When the eighth shift and a CPU read of the data location fall in the same cycle, ready ends at 1 and overrun stays 0.
- R7: Writing status bit 1 selects the direction (0 = receive, 1 = transmit). A change of direction restarts the bit count, and ready takes the new direction value.
- R8: In transmit mode, a CPU data write loads the register and clears ready. serDataOut shows bit 7, each serTick advances to the next lower bit, and ready returns to 1 after eight shifts. In receive mode serDataOut is 1.
- R9: In receive mode, a CPU write to the data location leaves the register and the status word unchanged.
- R10: progModeIn is sampled only while rstN is low. When it was high, cpuHold is 1 until the next reset, CPU writes are ignored, and the port stays in receive mode.
- R11: In programming mode, the cycle after the eighth bit is captured carries a one-cycle flashWrStrobe with flashWrData equal to the byte. flashByteAddr then advances by one, and ready stays 0.
- R12: When flashByteAddr wraps from all-ones, flashBlockAddr increments if rollEnable is 1 and stays unchanged if rollEnable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| progModeIn | input | 1 | Programming-mode request, sampled during reset |
| rollEnable | input | 1 | Allows the block address to advance on byte-address wrap |
| serTick | input | 1 | One-cycle pulse per serial bit time |
| serDataIn | input | 1 | Serial receive data |
| serDataOut | output | 1 | Serial transmit data, idle high |
| cpuSel | input | 1 | CPU access to the port this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 1 | 0 = data register, 1 = status/control |
| cpuWdata | input | DATA_W | CPU write data |
| cpuRdata | output | DATA_W | CPU read data for the selected location |
| cpuHold | output | 1 | Holds the CPU in reset during programming mode |
| flashWrStrobe | output | 1 | One-cycle flash data write request |
| flashWrData | output | DATA_W | Byte for the flash OR-write |
| flashByteAddr | output | BYTE_AW | Byte-in-block address |
| flashBlockAddr | output | BLOCK_AW | Block address |

## Verification
Two events can land in the same clock cycle: the eighth shift that raises ready, and the CPU data read that lowers it. The bench provokes this by driving the final serTick in the same cycle as a data-location read. It then requires ready to read 1 afterwards, overrun to stay 0, and the next read to return the new byte. A second coincidence happens during back-to-back programming: the forward strobe of one byte shares its cycle with the first tick of the next byte. This is judged through the exact final flash address after 32 and 64 streamed bytes.

// File: rtl/serial_loader_pkg.sv
package serial_loader_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic shiftEn;    // advance the shift register by one bit
    logic loadTx;     // load the register from the CPU write data
    logic txMode;     // level: 1 = transmit direction
    logic fwdStrobe;  // forward the held byte to flash, step the address
  } slStrobes_t;

  localparam int STATUS_BITS = 3;

endpackage

// File: rtl/serial_loader_ctrl.sv
module serial_loader_ctrl
  import serial_loader_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   progModeIn,
  input  logic                   serTick,
  input  logic                   cpuSel,
  input  logic                   cpuWrite,
  input  logic                   cpuAddr,
  input  logic                   wrModeBit,
  input  logic                   wrOvrClrBit,
  output slStrobes_t             strobes,
  output logic [STATUS_BITS-1:0] statusBits,
  output logic                   progActive
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             progActiveQ;
  logic             modeQ;
  logic             readyQ;
  logic             overrunQ;
  logic             fwdQ;
  logic [CNT_W-1:0] bitCntQ;

  logic dataRd, dataWr, statWr;
  logic modeChange, loadTx, shiftEn, lastShift, clrReady;

  // Programming mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) progActiveQ <= progModeIn;
  end

  // CPU accesses are masked while the CPU is held
  always_comb begin
    dataRd     = cpuSel && !cpuWrite && !cpuAddr && !progActiveQ;
    dataWr     = cpuSel &&  cpuWrite && !cpuAddr && !progActiveQ;
    statWr     = cpuSel &&  cpuWrite &&  cpuAddr && !progActiveQ;
    modeChange = statWr && (wrModeBit != modeQ);
    loadTx     = dataWr && modeQ;
    clrReady   = (dataRd && !modeQ) || loadTx;
    // A load or a direction change takes the cycle; the tick is dropped
    shiftEn    = serTick && !loadTx && !modeChange;
    lastShift  = shiftEn && (bitCntQ == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      readyQ   <= 1'b0;
      overrunQ <= 1'b0;
      fwdQ     <= 1'b0;
      bitCntQ  <= '0;
    end else begin
      if (statWr) modeQ <= wrModeBit;

      fwdQ <= lastShift && progActiveQ;

      if (modeChange || loadTx) bitCntQ <= '0;
      else if (lastShift)       bitCntQ <= '0;
      else if (shiftEn)         bitCntQ <= bitCntQ + 1'b1;

      // Completion wins over a same-cycle clear
      if (modeChange)                      readyQ <= wrModeBit;
      else if (lastShift && !progActiveQ)  readyQ <= 1'b1;
      else if (clrReady)                   readyQ <= 1'b0;

      // Setting wins over the write-one-to-clear
      if (shiftEn && readyQ && !clrReady)  overrunQ <= 1'b1;
      else if (statWr && wrOvrClrBit)      overrunQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.shiftEn   = shiftEn;
    strobes.loadTx    = loadTx;
    strobes.txMode    = modeQ;
    strobes.fwdStrobe = fwdQ;
    statusBits        = {overrunQ, modeQ, readyQ};
    progActive        = progActiveQ;
  end

endmodule

// File: rtl/serial_loader_datapath.sv
module serial_loader_datapath
  import serial_loader_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BYTE_AW  = 5,
  parameter int BLOCK_AW = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  slStrobes_t             strobes,
  input  logic                   serDataIn,
  input  logic                   rollEnable,
  input  logic                   cpuAddr,
  input  logic [DATA_W-1:0]      cpuWdata,
  input  logic [STATUS_BITS-1:0] statusBits,
  output logic                   serDataOut,
  output logic [DATA_W-1:0]      cpuRdata,
  output logic [DATA_W-1:0]      flashWrData,
  output logic [BYTE_AW-1:0]     flashByteAddr,
  output logic [BLOCK_AW-1:0]    flashBlockAddr
);

  localparam int PAD_W = DATA_W - STATUS_BITS;

  logic [DATA_W-1:0]   shRegQ;
  logic [BYTE_AW-1:0]  byteAddrQ;
  logic [BLOCK_AW-1:0] blockAddrQ;
  logic                shiftInBit;
  logic                byteWrap;

  // Transmit shifts zeros in behind the outgoing bits
  assign shiftInBit = strobes.txMode ? 1'b0 : serDataIn;

  always_ff @(posedge clk) begin
    if (!rstN)                shRegQ <= '0;
    else if (strobes.loadTx)  shRegQ <= cpuWdata;
    else if (strobes.shiftEn) shRegQ <= {shRegQ[DATA_W-2:0], shiftInBit};
  end

  assign byteWrap = (byteAddrQ == {BYTE_AW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteAddrQ  <= '0;
      blockAddrQ <= '0;
    end else if (strobes.fwdStrobe) begin
      byteAddrQ <= byteAddrQ + 1'b1;
      if (byteWrap && rollEnable) blockAddrQ <= blockAddrQ + 1'b1;
    end
  end

  always_comb begin
    serDataOut     = strobes.txMode ? shRegQ[DATA_W-1] : 1'b1;
    cpuRdata       = cpuAddr ? {{PAD_W{1'b0}}, statusBits} : shRegQ;
    flashWrData    = shRegQ;
    flashByteAddr  = byteAddrQ;
    flashBlockAddr = blockAddrQ;
  end

endmodule

// File: rtl/serial_loader.sv
module serial_loader
  import serial_loader_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BYTE_AW  = 5,
  parameter int BLOCK_AW = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progModeIn,
  input  logic                rollEnable,
  input  logic                serTick,
  input  logic                serDataIn,
  output logic                serDataOut,
  input  logic                cpuSel,
  input  logic                cpuWrite,
  input  logic                cpuAddr,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                cpuHold,
  output logic                flashWrStrobe,
  output logic [DATA_W-1:0]   flashWrData,
  output logic [BYTE_AW-1:0]  flashByteAddr,
  output logic [BLOCK_AW-1:0] flashBlockAddr
);

  slStrobes_t             ctlStrobes;
  logic [STATUS_BITS-1:0] statusBits;
  logic                   progActive;

  serial_loader_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .progModeIn (progModeIn),
    .serTick    (serTick),
    .cpuSel     (cpuSel),
    .cpuWrite   (cpuWrite),
    .cpuAddr    (cpuAddr),
    .wrModeBit  (cpuWdata[1]),
    .wrOvrClrBit(cpuWdata[2]),
    .strobes    (ctlStrobes),
    .statusBits (statusBits),
    .progActive (progActive)
  );

  serial_loader_datapath #(
    .DATA_W  (DATA_W),
    .BYTE_AW (BYTE_AW),
    .BLOCK_AW(BLOCK_AW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (ctlStrobes),
    .serDataIn     (serDataIn),
    .rollEnable    (rollEnable),
    .cpuAddr       (cpuAddr),
    .cpuWdata      (cpuWdata),
    .statusBits    (statusBits),
    .serDataOut    (serDataOut),
    .cpuRdata      (cpuRdata),
    .flashWrData   (flashWrData),
    .flashByteAddr (flashByteAddr),
    .flashBlockAddr(flashBlockAddr)
  );

  assign cpuHold       = progActive;
  assign flashWrStrobe = ctlStrobes.fwdStrobe;

endmodule

// File: rtl/serial_loader_chk.sv
module serial_loader_chk #(
  parameter int DATA_W   = 8,
  parameter int BYTE_AW  = 5,
  parameter int BLOCK_AW = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic                cpuSel,
  input logic                cpuWrite,
  input logic                cpuAddr,
  input logic [DATA_W-1:0]   cpuWdata,
  input logic                cpuHold,
  input logic                serDataOut,
  input logic                flashWrStrobe,
  input logic [BYTE_AW-1:0]  flashByteAddr,
  input logic [BLOCK_AW-1:0] flashBlockAddr,
  input logic                txMode,
  input logic                overrunBit
);

  // R11: the forward strobe lasts exactly one cycle
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |=> !flashWrStrobe);

  // R10: forwarding only happens while the CPU is held
  a_r10_fwd_only_held: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |-> cpuHold);

  // R10: the hold level never changes outside reset
  a_r10_hold_steady: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(cpuHold));

  // R11: each strobe advances the byte address by one
  a_r11_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    flashWrStrobe |=> (flashByteAddr == BYTE_AW'($past(flashByteAddr) + 1'b1)));

  // R11: without a strobe the flash address does not move
  a_r11_addr_still: assert property (@(posedge clk) disable iff (!rstN)
    !flashWrStrobe |=> ($stable(flashByteAddr) && $stable(flashBlockAddr)));

  // R12: the block only moves on a byte-address wrap
  a_r12_block_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrStrobe && (flashByteAddr != {BYTE_AW{1'b1}})) |=> $stable(flashBlockAddr));

  // R8: the line idles high in receive mode
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !txMode |-> serDataOut);

  // R5: overrun is sticky until a write-one-to-clear
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrunBit && !(cpuSel && cpuWrite && cpuAddr && cpuWdata[2])) |=> overrunBit);

endmodule

bind serial_loader serial_loader_chk #(
  .DATA_W  (DATA_W),
  .BYTE_AW (BYTE_AW),
  .BLOCK_AW(BLOCK_AW)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cpuSel        (cpuSel),
  .cpuWrite      (cpuWrite),
  .cpuAddr       (cpuAddr),
  .cpuWdata      (cpuWdata),
  .cpuHold       (cpuHold),
  .serDataOut    (serDataOut),
  .flashWrStrobe (flashWrStrobe),
  .flashByteAddr (flashByteAddr),
  .flashBlockAddr(flashBlockAddr),
  .txMode        (ctlStrobes.txMode),
  .overrunBit    (statusBits[2])
);

// File: tb/serial_loader_bench.sv
`timescale 1ns/1ps
module serial_loader_bench;

  localparam int DATA_W   = 8;
  localparam int BYTE_AW  = 5;
  localparam int BLOCK_AW = 7;
  localparam int BLOCK_BYTES = 1 << BYTE_AW;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                progModeIn = 1'b0;
  logic                rollEnable = 1'b0;
  logic                serTick = 1'b0;
  logic                serDataIn = 1'b0;
  logic                serDataOut;
  logic                cpuSel = 1'b0;
  logic                cpuWrite = 1'b0;
  logic                cpuAddr = 1'b0;
  logic [DATA_W-1:0]   cpuWdata = '0;
  logic [DATA_W-1:0]   cpuRdata;
  logic                cpuHold;
  logic                flashWrStrobe;
  logic [DATA_W-1:0]   flashWrData;
  logic [BYTE_AW-1:0]  flashByteAddr;
  logic [BLOCK_AW-1:0] flashBlockAddr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  serial_loader #(.DATA_W(DATA_W), .BYTE_AW(BYTE_AW), .BLOCK_AW(BLOCK_AW)) u_serial_loader (
    .clk(clk), .rstN(rstN), .progModeIn(progModeIn), .rollEnable(rollEnable),
    .serTick(serTick), .serDataIn(serDataIn), .serDataOut(serDataOut),
    .cpuSel(cpuSel), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuHold(cpuHold), .flashWrStrobe(flashWrStrobe),
    .flashWrData(flashWrData), .flashByteAddr(flashByteAddr), .flashBlockAddr(flashBlockAddr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic doReset(input logic prog);
    rstN = 1'b0;
    progModeIn = prog;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    progModeIn = ~prog;  // must not matter after reset
    @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    serTick = 1'b1;
    serDataIn = b;
    @(negedge clk);
    serTick = 1'b0;
  endtask

  task automatic sendBits(input logic [DATA_W-1:0] b, input int n);
    for (int i = DATA_W - 1; i > DATA_W - 1 - n; i--) shiftBit(b[i]);
  endtask

  task automatic cpuRd(input logic a, output logic [DATA_W-1:0] d);
    cpuSel = 1'b1; cpuWrite = 1'b0; cpuAddr = a;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuSel = 1'b0;
  endtask

  task automatic cpuWr(input logic a, input logic [DATA_W-1:0] d);
    cpuSel = 1'b1; cpuWrite = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuSel = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    doReset(1'b0);
    cpuRd(1'b1, d);
    check("R1 status", d, 0);
    check("R1 cpuHold", cpuHold, 0);
    check("R1 strobe", flashWrStrobe, 0);
    check("R1 idle line", serDataOut, 1);
    check("R1 addresses", {flashBlockAddr, flashByteAddr}, 0);
  endtask

  task automatic t_receive;
    logic [DATA_W-1:0] d;
    sendBits(8'hA5, 7);
    cpuRd(1'b1, d);
    check("R3 not ready after 7", d, 8'h00);
    shiftBit(1'b1);
    cpuRd(1'b1, d);
    check("R3 ready after 8", d, 8'h01);
    cpuRd(1'b0, d);
    check("R2 byte msb first", d, 8'hA5);
    cpuRd(1'b1, d);
    check("R4 read clears ready", d, 8'h00);
  endtask

  task automatic t_overrun;
    logic [DATA_W-1:0] d;
    sendBits(8'h5A, 8);
    shiftBit(1'b1);
    cpuRd(1'b1, d);
    check("R5 overrun set", d, 8'h05);
    cpuRd(1'b0, d);
    check("R5 register kept shifting", d, 8'hB5);
    cpuWr(1'b1, 8'h04);
    cpuRd(1'b1, d);
    check("R5 overrun cleared", d, 8'h00);
    // realign bit count by toggling direction
    cpuWr(1'b1, 8'h02);
    cpuWr(1'b1, 8'h00);
  endtask

  task automatic t_collision;
    logic [DATA_W-1:0] d;
    sendBits(8'h3C, 7);
    // eighth shift and a data read in the same cycle
    cpuSel = 1'b1; cpuWrite = 1'b0; cpuAddr = 1'b0;
    serTick = 1'b1; serDataIn = 1'b0;
    @(negedge clk);
    serTick = 1'b0; cpuSel = 1'b0;
    cpuRd(1'b1, d);
    check("R6 ready survives clear", d, 8'h01);
    cpuRd(1'b0, d);
    check("R6 new byte present", d, 8'h3C);
  endtask

  task automatic t_ignore;
    logic [DATA_W-1:0] d;
    cpuWr(1'b0, 8'hFF);
    cpuRd(1'b0, d);
    check("R9 rx write ignored data", d, 8'h3C);
    cpuRd(1'b1, d);
    check("R9 rx write ignored status", d, 8'h00);
  endtask

  task automatic t_transmit;
    logic [DATA_W-1:0] d;
    logic [DATA_W-1:0] tx;
    tx = 8'hC6;
    cpuWr(1'b1, 8'h02);
    cpuRd(1'b1, d);
    check("R7 tx mode ready", d, 8'h03);
    cpuWr(1'b0, tx);
    cpuRd(1'b1, d);
    check("R8 load clears ready", d, 8'h02);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      check("R8 tx bit", serDataOut, tx[i]);
      if (i == 0) begin
        cpuRd(1'b1, d);
        check("R8 not ready before last", d, 8'h02);
      end
      shiftBit(1'b0);
    end
    cpuRd(1'b1, d);
    check("R8 ready after 8 tx shifts", d, 8'h03);
    cpuWr(1'b1, 8'h00);
    cpuRd(1'b1, d);
    check("R7 back to rx", d, 8'h00);
    check("R8 rx idle high", serDataOut, 1);
  endtask

  task automatic t_prog;
    logic [DATA_W-1:0] d;
    doReset(1'b1);
    check("R10 cpu held", cpuHold, 1);
    cpuWr(1'b1, 8'h02);
    cpuRd(1'b1, d);
    check("R10 cpu write ignored", d, 8'h00);
    sendBits(8'h81, 8);
    check("R11 strobe after capture", flashWrStrobe, 1);
    check("R11 forwarded data", flashWrData, 8'h81);
    check("R11 address before step", flashByteAddr, 0);
    cpuRd(1'b1, d);
    check("R11 ready stays low", d, 8'h00);
    check("R11 single pulse", flashWrStrobe, 0);
    check("R11 address stepped", flashByteAddr, 1);
    check("R10 still held", cpuHold, 1);
  endtask

  task automatic t_roll;
    rollEnable = 1'b0;
    for (int n = 1; n < BLOCK_BYTES; n++) sendBits(DATA_W'(n), 8);
    @(negedge clk);
    check("R12 no roll byte", flashByteAddr, 0);
    check("R12 no roll block", flashBlockAddr, 0);
    rollEnable = 1'b1;
    for (int n = 0; n < BLOCK_BYTES; n++) sendBits(DATA_W'(n ^ 8'h5A), 8);
    @(negedge clk);
    check("R12 roll byte", flashByteAddr, 0);
    check("R12 roll block", flashBlockAddr, 1);
    doReset(1'b0);
    check("R10 released by reset", cpuHold, 0);
    check("R1 addresses after reset", {flashBlockAddr, flashByteAddr}, 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_receive;
    t_overrun;
    t_collision;
    t_ignore;
    t_transmit;
    t_prog;
    t_roll;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule